// File: doc/BRIEF.md
# Fractional log2 lookup unit

This unit returns the base-2 logarithm of an unsigned fixed-point operand between 1.0 (inclusive) and 2.0 (exclusive). On every rising clock edge the operand is loaded into a register. A lookup table is read from that register with no further register, so each result is valid one edge after its operand is presented and stays steady until the next edge.

The integer bit of a legal operand is always 1, so only the fraction bits address the table. This halves the table. The table is filled at elaboration by a constant function using integer arithmetic, and no memory file is read. A caller that needs the logarithm of an operand outside the range scales it by a power of two first and adds that exponent to the result. The unit has no control state beyond the operand register. A separate flag reports a captured operand whose integer bit is 0.

Top module: `fraclog2_unit`

## Requirements
- R1: The operand `x_in` is loaded into a register on each rising edge of `clk`. `y_out` and `range_err` depend only on that register, so the result for an operand appears after exactly one rising edge.
- R2: Bit 11 of `x_in` (weight 2^0) is not used to select the result. Operands that differ only in bit 11 give the same `y_out`.
- R3: With k = `x_in[10:0]` (weights 2^-1 to 2^-11), `y_out` equals round(log2(1 + k/2048) * 65536), with halves rounded up and the result capped at 16'hFFFF. `y_out[15]` carries weight 2^-1 and `y_out[0]` carries weight 2^-16.
- R4: The result rises strictly as k rises. k = 0 gives 16'h0000, and k = 2047 gives the largest value in the table with no wrap-around.
- R5: A synchronous active-high `rst` loads the operand register with 12'h800 (1.0). While reset is held and after it is released, `y_out` reads 0 and `range_err` reads 0 until a new operand is captured.
- R6: `range_err` is 1 exactly when the captured operand has bit 11 equal to 0. It is valid in the same cycle as the result for that operand, and that result still follows R3.
- R7: A change on `x_in` between clock edges does not change `y_out` or `range_err` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operand captured on rising edge |
| rst | input | 1 | Synchronous active-high reset to operand 1.0 |
| x_in | input | 12 | Operand, unsigned, binary point after bit 11 |
| y_out | output | 16 | log2 of captured operand, unsigned fraction |
| range_err | output | 1 | Captured operand has integer bit 0 |

## Verification
A wrong value in the operand register shows up one edge later as a wrong `y_out` or `range_err`, and it lasts for the whole cycle. A single corrupted table entry shows up only when its own address is captured. For that reason every one of the 4096 operand codes is driven, and each result is compared against a real-number logarithm computed in the bench. A stray path from the input to the output shows as a change in the result before the next edge. A wrong reset value shows as a nonzero result right after reset.

// File: rtl/l2_pkg.sv
package l2_pkg;

    // Width of the fixed-point scratch value used while building the table.
    localparam int unsigned WORK_FRAC = 30;
    // Extra result bits computed below the kept LSB, used for rounding.
    localparam int unsigned GUARD     = 8;

    // Returns round(log2(1 + k / 2^fbits) * 2^obits), capped at all ones.
    // Bits of the logarithm are produced one at a time by repeated squaring:
    // when the squared value reaches 2 the next bit is 1 and the value halves.
    // Requires fbits <= WORK_FRAC and obits + GUARD <= 40.
    function automatic logic [31:0] log2_entry(input int unsigned k,
                                               input int unsigned fbits,
                                               input int unsigned obits);
        longint unsigned x;
        longint unsigned acc;
        longint unsigned top;
        longint unsigned two;
        int unsigned     nbits;
        nbits = obits + GUARD;
        two   = longint'(64'd1) << (WORK_FRAC + 1);
        x     = (longint'(64'd1) << WORK_FRAC) + (longint'(k) << (WORK_FRAC - fbits));
        acc   = 64'd0;
        for (int unsigned i = 0; i < nbits; i++) begin
            x   = (x * x) >> WORK_FRAC;
            acc = acc << 1;
            if (x >= two) begin
                acc = acc | 64'd1;
                x   = x >> 1;
            end
        end
        acc = (acc + (longint'(64'd1) << (GUARD - 1))) >> GUARD;
        top = (longint'(64'd1) << obits) - 64'd1;
        if (acc > top) acc = top;
        return acc[31:0];
    endfunction

endpackage

// File: rtl/l2_capture.sv
module l2_capture #(
    parameter int unsigned IN_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] d,
    output logic [IN_W-2:0] addr,
    output logic            msb_zero
);
    localparam logic [IN_W-1:0] ONE_VAL = {1'b1, {(IN_W-1){1'b0}}};

    logic [IN_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= ONE_VAL;
        else     q <= d;
    end

    assign addr     = q[IN_W-2:0];
    assign msb_zero = ~q[IN_W-1];

    // R5: right after reset the held operand is 1.0
    assert_reset_value_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr == '0 && !msb_zero));

    // R1: the register follows the input by one edge
    assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> addr == $past(d[IN_W-2:0]));

endmodule

// File: rtl/l2_table.sv
module l2_table #(
    parameter int unsigned FRAC_W = 11,
    parameter int unsigned OUT_W  = 16
) (
    input  logic [FRAC_W-1:0] addr,
    output logic [OUT_W-1:0]  data
);
    localparam int unsigned DEPTH = 1 << FRAC_W;

    logic [OUT_W-1:0] rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam logic [31:0] VAL = l2_pkg::log2_entry(k, FRAC_W, OUT_W);
        assign rom[k] = VAL[OUT_W-1:0];
    end

    assign data = rom[addr];

endmodule

// File: rtl/fraclog2_unit.sv
module fraclog2_unit #(
    parameter int unsigned IN_W  = 12,
    parameter int unsigned OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  x_in,
    output logic [OUT_W-1:0] y_out,
    output logic             range_err
);
    localparam int unsigned FRAC_W = IN_W - 1;

    logic [FRAC_W-1:0] addr;
    logic              warm;

    l2_capture #(.IN_W(IN_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .d        (x_in),
        .addr     (addr),
        .msb_zero (range_err)
    );

    l2_table #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_table (
        .addr (addr),
        .data (y_out)
    );

    // Marks cycles whose captured operand came from x_in, not from reset.
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    // R6: flag mirrors the integer bit of the operand captured one edge earlier
    assert_flag_tracks_R6: assert property (@(posedge clk) disable iff (rst)
        warm |-> range_err == !$past(x_in[IN_W-1]));

    // R4: zero fraction gives a zero logarithm
    assert_zero_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(x_in[FRAC_W-1:0]) == '0) |-> y_out == '0);

    // R2: same fraction bits on consecutive operands keep the result fixed
    assert_msb_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(warm) &&
         $past(x_in[FRAC_W-1:0]) == $past(x_in[FRAC_W-1:0], 2)) |-> $stable(y_out));

    // R4: a larger fraction gives a strictly larger result
    assert_strict_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(warm) &&
         $past(x_in[FRAC_W-1:0]) > $past(x_in[FRAC_W-1:0], 2)) |-> y_out > $past(y_out));

endmodule

// File: tb/fraclog2_unit_bench.sv
module fraclog2_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] x_in = 12'h800;
    logic [15:0] y_out;
    logic        range_err;

    int total = 0;
    int bad   = 0;

    fraclog2_unit u_fraclog2_unit (
        .clk       (clk),
        .rst       (rst),
        .x_in      (x_in),
        .y_out     (y_out),
        .range_err (range_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Directed operands: edges, alternating patterns, illegal-MSB codes.
    localparam logic [11:0] VEC [10] = '{
        12'h800, 12'hFFF, 12'h555, 12'hAAA, 12'h000,
        12'h801, 12'hC00, 12'h7FF, 12'h9A3, 12'h400
    };

    function automatic int ref_log(input logic [11:0] v);
        real r;
        int  n;
        r = $ln(1.0 + real'(int'(v[10:0])) / 2048.0) / $ln(2.0) * 65536.0;
        n = $rtoi(r + 0.5);
        if (n > 65535) n = 65535;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one rising edge between).
    task automatic apply(input logic [11:0] v, input string req);
        @(negedge clk);
        x_in = v;
        @(negedge clk);
        check(req, int'(y_out), ref_log(v));
        check("R6", int'(range_err), v[11] ? 0 : 1);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int prev;
        int hold;
        repeat (3) @(negedge clk);
        // R5: held in reset
        check("R5", int'(y_out), 0);
        check("R5", int'(range_err), 0);
        rst = 1'b0;
        x_in = 12'h800;
        @(negedge clk);
        check("R5", int'(y_out), 0);

        // Vector table walk (R3, R4 edges, R6 flag)
        for (int i = 0; i < 10; i++) apply(VEC[i], "R3");
        // R4: extreme codes directly
        apply(12'h800, "R4");
        check("R4", int'(y_out), 0);
        apply(12'hFFF, "R4");
        check("R4", int'(y_out), ref_log(12'hFFF));

        // Full sweep of every operand code, R3, plus R4 strict rise on legal codes
        prev = -1;
        for (int v = 0; v < 4096; v++) begin
            apply(12'(v), "R3");
            if (v >= 2048) begin
                if (int'(y_out) <= prev && v > 2048) begin
                    bad++;
                    $display("FAIL R4: actual=%0d expected>%0d", y_out, prev);
                end
                total++;
                prev = int'(y_out);
            end
        end

        // R2: MSB does not select the result
        apply(12'h123, "R2");
        hold = int'(y_out);
        apply(12'h923, "R2");
        check("R2", int'(y_out), hold);

        // R1 and R7: input change mid-cycle does not reach the output
        apply(12'hA10, "R1");
        hold = int'(y_out);
        @(negedge clk);
        x_in = 12'h0F0;
        #(CLK_PERIOD/2 - 1);
        check("R7", int'(y_out), hold);
        check("R7", int'(range_err), 0);
        @(negedge clk);
        check("R1", int'(y_out), ref_log(12'h0F0));
        check("R1", int'(range_err), 1);

        // R5: reset mid-run returns to 1.0
        @(negedge clk);
        x_in = 12'h3FF;
        rst = 1'b1;
        @(negedge clk);
        check("R5", int'(y_out), 0);
        check("R5", int'(range_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(y_out), ref_log(12'h3FF));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule